// File: doc/BRIEF.md
# Controller Bring-Up Sequencer

This block walks a serial-link controller out of reset with a fixed, timed recipe. While idle it holds the core in soft reset, keeps the PHY powered down and keeps the reference clock off. A start request enables the controller's clocks one at a time. Each enable waits for that clock's acknowledge before the next is raised. Once the last clock reports good, the PHY is powered up. The reference clock follows a guard interval later, so the PHY's internally synchronised reset lasts long enough.

After the reference clock acknowledges, the block lets the clocks settle. If the board has an external reset line, it then drives that line active for a set time with a strap-selected polarity, and otherwise skips this step. The core soft reset is released next, with an optional extra wait before done is raised. If an acknowledge never arrives, the enabled clocks are switched off again newest-first and an error is reported. A hold command returns the block to its reset-holding state from any point and is also the shutdown path.

All delays are given in microseconds and converted to cycles from a clock-frequency parameter. A bench can therefore shrink them.

Top module: `pwr_bringup_seq`

## Requirements
- R1: Clock enables rise strictly in order. Bit 0 is the PHY clock, bit 1 the bus clock and bit 2 the core clock; acknowledge bit i belongs to clock i and acknowledge bit NCLK to the reference clock. Enable 0 rises on the first edge after an accepted start. Enable i+1 rises on the first edge on which acknowledge i is seen.
- R2: If a stage's acknowledge has not arrived within ACK_TMO cycles of its enable, the enabled clocks are cleared one per cycle from the highest index down. The first is cleared ACK_TMO+1 cycles after that enable rose, and the error output rises together with the clearing of clock 0. On a reference-clock timeout, the reference enable drops and PHY power-down returns ACK_TMO cycles after the reference enable rose, and the core clock is cleared one cycle later.
- R3: PHY power-down is released on the edge that accepts the last clock's acknowledge. The reference enable rises exactly GUARD cycles later.
- R4: Counting from the edge that accepts the reference acknowledge, the settle wait lasts SETTLE cycles before the external pulse or the soft-reset release step starts.
- R5: With the external line present, the external reset is active for exactly PULSE cycles. Active level is high when the polarity strap is 1 and low when it is 0. It sits at the inactive level at all other times.
- R6: With no external line, the external reset never goes active, and the core reset falls SETTLE+1 cycles after the reference acknowledge is accepted.
- R7: The core reset falls one cycle after the external pulse ends. Done rises POST cycles after that when the post-wait strap is 1, and together with it when the strap is 0.
- R8: A hold command makes, on the next edge, the core reset 1, PHY power-down 1, reference enable 0, external reset inactive and done 0. The clock enables are left unchanged.
- R9: The three straps are sampled only when a start is accepted, and start is ignored unless the block is idle, including in the error state.
- R10: A delay of D microseconds lasts floor(D*CLK_KHZ/1000) cycles, with a minimum of 1.
- R11: After reset, the clock enables and reference enable are 0, PHY power-down and core reset are 1, the external reset is 1 (inactive for the reset polarity, active-low), and done and error are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the bring-up sequence (accepted when idle) |
| hold_i | input | 1 | Return to reset-holding state (also shutdown) |
| ack_i | input | NCLK+1 | Per-clock good acknowledge; top bit is the reference clock |
| ext_present_i | input | 1 | Strap: external reset line fitted |
| ext_pol_i | input | 1 | Strap: external reset active level (1 = high) |
| post_wait_i | input | 1 | Strap: add the wait after soft-reset release |
| clk_en_o | output | NCLK | Ordered clock enables |
| phy_pd_o | output | 1 | PHY power-down |
| ref_en_o | output | 1 | Reference clock enable |
| ext_rst_o | output | 1 | External reset line |
| core_rst_o | output | 1 | Core soft reset |
| done_o | output | 1 | Sequence finished, controller released |
| err_o | output | 1 | A clock stage timed out and was unwound |

## Verification
Inputs change just after the falling edge and outputs are sampled at the next falling edge. A stage reacting to an acknowledge therefore shows its output one sample after that acknowledge went high. Timer-gated outputs appear exactly their cycle count after the output that started the timer: GUARD from power-up to reference enable, PULSE for the external width, POST from soft-reset release to done. Settle is measured from the reference acknowledge and so carries one extra cycle (two when the pulse is skipped), and an unwind starts ACK_TMO+1 samples after the stalled enable. The bench records the sample index of every edge of every output, compares differences of those indices with figures it derives from the microsecond parameters, and redraws acknowledge delays and strap values after each start.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CLK,
    ST_GUARD,
    ST_REFACK,
    ST_SETTLE,
    ST_PULSE,
    ST_REL,
    ST_POST,
    ST_DONE,
    ST_UNWIND,
    ST_FAIL
  } seq_state_e;

  // microseconds to cycles at a clock given in kHz, never below one cycle
  function automatic longint unsigned us_to_cycles(input longint unsigned us,
                                                   input longint unsigned khz);
    longint unsigned c;
    c = (us * khz) / 64'd1000;
    if (c == 64'd0) c = 64'd1;
    return c;
  endfunction

  // number of bits needed to hold the value v
  function automatic int bits_for(input longint unsigned v);
    int b;
    b = 1;
    while ((v >> b) != 64'd0) b++;
    return b;
  endfunction

  function automatic longint unsigned max2(input longint unsigned a,
                                           input longint unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  // R10: an expired timer stays expired until reloaded
  a_r10_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

  // R10: a nonzero load is never reported as expired on the next cycle
  a_r10_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (load_val_i != '0)) |=> !zero_o);

endmodule

// File: rtl/clk_bank.sv
module clk_bank #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [IW-1:0] sel_i,
  output logic [N-1:0]  en_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hit;
    assign hit = (sel_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_o[g] <= 1'b0;
      end else if (set_i && hit) begin
        en_o[g] <= 1'b1;
      end else if (clr_i && hit) begin
        en_o[g] <= 1'b0;
      end
    end
  end

  // R2: enables change at most one at a time, on power-up and on unwind
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(en_o ^ $past(en_o)) <= 1);

endmodule

// File: rtl/pwr_bringup_seq.sv
module pwr_bringup_seq
  import pwrseq_pkg::*;
#(
  parameter int NCLK      = 3,
  parameter int CLK_KHZ   = 100000,
  parameter int GUARD_US  = 10,
  parameter int SETTLE_US = 200,
  parameter int PULSE_US  = 100000,
  parameter int POST_US   = 200,
  parameter int ACK_TMO   = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            hold_i,
  input  logic [NCLK:0]   ack_i,
  input  logic            ext_present_i,
  input  logic            ext_pol_i,
  input  logic            post_wait_i,
  output logic [NCLK-1:0] clk_en_o,
  output logic            phy_pd_o,
  output logic            ref_en_o,
  output logic            ext_rst_o,
  output logic            core_rst_o,
  output logic            done_o,
  output logic            err_o
);

  localparam longint unsigned GUARD_CYC  = us_to_cycles(GUARD_US, CLK_KHZ);
  localparam longint unsigned SETTLE_CYC = us_to_cycles(SETTLE_US, CLK_KHZ);
  localparam longint unsigned PULSE_CYC  = us_to_cycles(PULSE_US, CLK_KHZ);
  localparam longint unsigned POST_CYC   = us_to_cycles(POST_US, CLK_KHZ);
  localparam longint unsigned TMO_CYC    = (ACK_TMO < 1) ? 64'd1 : 64'(ACK_TMO);
  localparam longint unsigned MAX_CYC    =
    max2(max2(max2(GUARD_CYC, SETTLE_CYC), max2(PULSE_CYC, POST_CYC)), TMO_CYC);
  localparam int TW = bits_for(MAX_CYC);
  localparam int IW = (NCLK > 1) ? $clog2(NCLK) : 1;

  localparam logic [TW-1:0] GUARD_LD  = TW'(GUARD_CYC - 1);
  localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] POST_LD   = TW'(POST_CYC - 1);
  localparam logic [TW-1:0] TMO_LD    = TW'(TMO_CYC - 1);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NCLK - 1);

  seq_state_e st_q, st_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          pd_q, pd_n;
  logic          ref_q, ref_n;
  logic          core_q, core_n;
  logic          pres_q, pol_q, post_q;

  // named internal events
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_zero;
  logic          bank_set, bank_clr;
  logic [IW-1:0] bank_sel;
  logic          start_take;
  logic          stage_ack;
  logic          stage_tmo;
  logic          ext_active;

  assign start_take = (st_q == ST_IDLE) && start_i && !hold_i;
  assign stage_ack  = (st_q == ST_CLK) ? ack_i[idx_q] : ack_i[NCLK];
  assign stage_tmo  = tmr_zero && !stage_ack;
  assign ext_active = (st_q == ST_PULSE);

  seq_timer #(.W(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  clk_bank #(.N(NCLK), .IW(IW)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (bank_set),
    .clr_i (bank_clr),
    .sel_i (bank_sel),
    .en_o  (clk_en_o)
  );

  always_comb begin
    st_n     = st_q;
    idx_n    = idx_q;
    pd_n     = pd_q;
    ref_n    = ref_q;
    core_n   = core_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    bank_set = 1'b0;
    bank_clr = 1'b0;
    bank_sel = idx_q;
    if (hold_i) begin
      st_n   = ST_IDLE;
      pd_n   = 1'b1;
      ref_n  = 1'b0;
      core_n = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_n     = ST_CLK;
            idx_n    = '0;
            bank_set = 1'b1;
            bank_sel = '0;
            tmr_load = 1'b1;
            tmr_val  = TMO_LD;
          end
        end
        ST_CLK: begin
          if (stage_ack) begin
            if (idx_q == LAST_IDX) begin
              pd_n     = 1'b0;
              st_n     = ST_GUARD;
              tmr_load = 1'b1;
              tmr_val  = GUARD_LD;
            end else begin
              idx_n    = idx_q + 1'b1;
              bank_set = 1'b1;
              bank_sel = idx_q + 1'b1;
              tmr_load = 1'b1;
              tmr_val  = TMO_LD;
            end
          end else if (stage_tmo) begin
            st_n = ST_UNWIND;
          end
        end
        ST_GUARD: begin
          if (tmr_zero) begin
            ref_n    = 1'b1;
            st_n     = ST_REFACK;
            tmr_load = 1'b1;
            tmr_val  = TMO_LD;
          end
        end
        ST_REFACK: begin
          if (stage_ack) begin
            st_n     = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
          end else if (stage_tmo) begin
            ref_n = 1'b0;
            pd_n  = 1'b1;
            idx_n = LAST_IDX;
            st_n  = ST_UNWIND;
          end
        end
        ST_SETTLE: begin
          if (tmr_zero) begin
            if (pres_q) begin
              st_n     = ST_PULSE;
              tmr_load = 1'b1;
              tmr_val  = PULSE_LD;
            end else begin
              st_n = ST_REL;
            end
          end
        end
        ST_PULSE: begin
          if (tmr_zero) st_n = ST_REL;
        end
        ST_REL: begin
          core_n = 1'b0;
          if (post_q) begin
            st_n     = ST_POST;
            tmr_load = 1'b1;
            tmr_val  = POST_LD;
          end else begin
            st_n = ST_DONE;
          end
        end
        ST_POST: begin
          if (tmr_zero) st_n = ST_DONE;
        end
        ST_DONE: begin
          st_n = ST_DONE;
        end
        ST_UNWIND: begin
          bank_clr = 1'b1;
          bank_sel = idx_q;
          pd_n     = 1'b1;
          if (idx_q == '0) st_n = ST_FAIL;
          else             idx_n = idx_q - 1'b1;
        end
        ST_FAIL: begin
          st_n = ST_FAIL;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      pd_q   <= 1'b1;
      ref_q  <= 1'b0;
      core_q <= 1'b1;
      pres_q <= 1'b0;
      pol_q  <= 1'b0;
      post_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      idx_q  <= idx_n;
      pd_q   <= pd_n;
      ref_q  <= ref_n;
      core_q <= core_n;
      if (start_take) begin
        pres_q <= ext_present_i;
        pol_q  <= ext_pol_i;
        post_q <= post_wait_i;
      end
    end
  end

  assign phy_pd_o   = pd_q;
  assign ref_en_o   = ref_q;
  assign core_rst_o = core_q;
  assign ext_rst_o  = ext_active ? pol_q : ~pol_q;
  assign done_o     = (st_q == ST_DONE);
  assign err_o      = (st_q == ST_FAIL);

  // R1: a clock enable rises only above an enabled, acknowledged predecessor
  for (genvar g = 1; g < NCLK; g++) begin : g_order
    a_r1_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_o[g]) |-> (clk_en_o[g-1] && $past(ack_i[g-1])));
  end

  // R3: reference clock rises only with the PHY powered, straight after the guard
  a_r3_guard_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en_o) |-> (!phy_pd_o && $past(st_q == ST_GUARD)));

  // R5: the external pulse happens only while the core is held
  a_r5_pulse_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |-> core_rst_o);

  // R7: done means everything is up and the core is released
  a_r7_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!core_rst_o && ref_en_o && !phy_pd_o && (&clk_en_o)));

  // R2: after an unwind nothing is left enabled
  a_r2_err_clean: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ((clk_en_o == '0) && !ref_en_o && phy_pd_o));

  // R8: hold puts the controller back into its held state
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (core_rst_o && phy_pd_o && !ref_en_o && !done_o && !err_o));

  // R9: done and error never coexist
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));

endmodule

// File: tb/sim_pwr_bringup_seq.sv
`timescale 1ns/1ps
module sim_pwr_bringup_seq;

  localparam int NCLK = 3;
  localparam int KHZ  = 2000;
  localparam int G_US = 10;
  localparam int S_US = 15;
  localparam int P_US = 20;
  localparam int O_US = 12;
  localparam int TMO  = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic            hold_i = 1'b0;
  logic [NCLK:0]   ack_i = '0;
  logic            ext_present_i = 1'b0;
  logic            ext_pol_i = 1'b0;
  logic            post_wait_i = 1'b0;
  logic [NCLK-1:0] clk_en_o;
  logic            phy_pd_o, ref_en_o, ext_rst_o, core_rst_o, done_o, err_o;

  pwr_bringup_seq #(
    .NCLK(NCLK), .CLK_KHZ(KHZ), .GUARD_US(G_US), .SETTLE_US(S_US),
    .PULSE_US(P_US), .POST_US(O_US), .ACK_TMO(TMO)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(hold_i), .ack_i(ack_i),
    .ext_present_i(ext_present_i), .ext_pol_i(ext_pol_i), .post_wait_i(post_wait_i),
    .clk_en_o(clk_en_o), .phy_pd_o(phy_pd_o), .ref_en_o(ref_en_o),
    .ext_rst_o(ext_rst_o), .core_rst_o(core_rst_o), .done_o(done_o), .err_o(err_o)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // R10 restated: microseconds scaled by kHz, floor, at least one
  function automatic int cyc_of(input int us);
    int c;
    c = (us * KHZ) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_i = 1'b0; hold_i = 1'b0; ack_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset();
    check(clk_en_o == '0, "R11", "clk_en after reset", int'(clk_en_o), 0);
    check(phy_pd_o && core_rst_o && !ref_en_o, "R11", "pd/core/ref after reset",
          {phy_pd_o, core_rst_o, ref_en_o}, 3'b110);
    check(ext_rst_o == 1'b1, "R11", "ext reset after reset", ext_rst_o, 1);
    check(!done_o && !err_o, "R11", "done/err after reset", {done_o, err_o}, 0);
  endtask

  // mode 0: full run with end checks; 1: hold during pulse; 2: hold after done
  task automatic run(input bit gp, input bit pol, input bit post,
                     input int blk, input int mode);
    int rise[NCLK+1], fall[NCLK+1], tack[NCLK+1], cnt[NCLK+1], dly[NCLK+1];
    int tpd_f, tpd_r, tx_r, tx_f, tcore, tdone, terr, n, tail;
    bit xbad, held;
    for (int i = 0; i <= NCLK; i++) begin
      rise[i] = -1; fall[i] = -1; tack[i] = -1; cnt[i] = 0;
      dly[i] = $urandom_range(0, 4);
    end
    tpd_f = -1; tpd_r = -1; tx_r = -1; tx_f = -1; tcore = -1; tdone = -1; terr = -1;
    xbad = 0; held = 0; tail = -1;
    do_reset();
    check_reset();
    ext_present_i = gp; ext_pol_i = pol; post_wait_i = post; start_i = 1'b1;
    n = 0;
    while (n < 3000) begin
      bit en, act;
      @(negedge clk);
      n++;
      if (held) begin
        check(core_rst_o && phy_pd_o && !ref_en_o && !done_o, "R8",
              "held outputs", {core_rst_o, phy_pd_o, ref_en_o, done_o}, 4'b1100);
        check(ext_rst_o == ~pol, "R8", "ext inactive after hold", ext_rst_o, ~pol);
        check(clk_en_o == '1, "R8", "clocks kept on hold", int'(clk_en_o), 7);
        hold_i = 1'b0;
        break;
      end
      for (int i = 0; i <= NCLK; i++) begin
        en = (i < NCLK) ? clk_en_o[i] : ref_en_o;
        if (en && rise[i] < 0) rise[i] = n;
        if (!en && rise[i] >= 0 && fall[i] < 0) fall[i] = n;
      end
      if (!phy_pd_o && tpd_f < 0) tpd_f = n;
      if (phy_pd_o && tpd_f >= 0 && tpd_r < 0) tpd_r = n;
      act = (ext_rst_o == pol);
      if (act && tx_r < 0) tx_r = n;
      if (act && tx_f >= 0) xbad = 1;
      if (!act && tx_r >= 0 && tx_f < 0) tx_f = n;
      if (!core_rst_o && tcore < 0) tcore = n;
      if (done_o && tdone < 0) tdone = n;
      if (err_o && terr < 0) terr = n;
      // drive after sampling
      start_i = (mode == 0) ? 1'($urandom_range(0, 1)) : 1'b0;
      ext_present_i = 1'($urandom_range(0, 1));
      ext_pol_i = 1'($urandom_range(0, 1));
      post_wait_i = 1'($urandom_range(0, 1));
      for (int i = 0; i <= NCLK; i++) begin
        en = (i < NCLK) ? clk_en_o[i] : ref_en_o;
        if (en) begin
          if (!ack_i[i] && cnt[i] >= dly[i] && i != blk) begin
            ack_i[i] = 1'b1;
            tack[i] = n;
          end
          cnt[i]++;
        end else begin
          cnt[i] = 0;
          ack_i[i] = 1'b0;
        end
      end
      if (mode == 1 && tx_r >= 0) begin hold_i = 1'b1; held = 1; end
      if (mode == 2 && tdone >= 0) begin hold_i = 1'b1; held = 1; end
      if (tail < 0 && (tdone >= 0 || terr >= 0)) tail = n + 4;
      if (tail >= 0 && n >= tail) break;
    end
    start_i = 1'b0;
    if (mode != 0) return;
    if (blk < 0) begin
      check(rise[0] == 1, "R1", "clock 0 rise after start", rise[0], 1);
      for (int i = 1; i < NCLK; i++)
        check(rise[i] - tack[i-1] == 1, "R1", "next clock after ack",
              rise[i] - tack[i-1], 1);
      check(tpd_f - tack[NCLK-1] == 1, "R3", "phy power-up after last ack",
            tpd_f - tack[NCLK-1], 1);
      check(rise[NCLK] - tpd_f == cyc_of(G_US), "R3", "guard to ref enable",
            rise[NCLK] - tpd_f, cyc_of(G_US));
      if (gp) begin
        check(tx_r - tack[NCLK] == cyc_of(S_US) + 1, "R4", "settle before pulse",
              tx_r - tack[NCLK], cyc_of(S_US) + 1);
        check(tx_f - tx_r == cyc_of(P_US), "R5", "pulse width",
              tx_f - tx_r, cyc_of(P_US));
        check(!xbad, "R5", "single pulse", xbad, 0);
        check(tcore - tx_f == 1, "R7", "core release after pulse", tcore - tx_f, 1);
      end else begin
        check(tx_r < 0, "R6", "no pulse without line", tx_r, -1);
        check(tcore - tack[NCLK] == cyc_of(S_US) + 2, "R6", "core release, no line",
              tcore - tack[NCLK], cyc_of(S_US) + 2);
      end
      check(tdone - tcore == (post ? cyc_of(O_US) : 0), "R7", "done after release",
            tdone - tcore, post ? cyc_of(O_US) : 0);
      check(terr < 0 && done_o, "R9", "done held, start ignored", done_o, 1);
    end else if (blk < NCLK) begin
      check(fall[blk] - rise[blk] == TMO + 1, "R2", "unwind start after timeout",
            fall[blk] - rise[blk], TMO + 1);
      for (int j = 0; j < blk; j++)
        check(fall[j] - fall[blk] == blk - j, "R2", "reverse unwind order",
              fall[j] - fall[blk], blk - j);
      if (blk + 1 < NCLK)
        check(rise[blk+1] < 0, "R2", "later clock never enabled", rise[blk+1], -1);
      check(tpd_f < 0, "R2", "phy stays powered down", tpd_f, -1);
      check(terr == fall[0], "R2", "error with last clear", terr, fall[0]);
      check(err_o && clk_en_o == '0, "R9", "error stays under start",
            {err_o, clk_en_o}, 8);
    end else begin
      check(fall[NCLK] - rise[NCLK] == TMO, "R2", "ref drop on timeout",
            fall[NCLK] - rise[NCLK], TMO);
      check(tpd_r == fall[NCLK], "R2", "phy power-down back", tpd_r, fall[NCLK]);
      check(fall[NCLK-1] - rise[NCLK] == TMO + 1, "R2", "core clock cleared next",
            fall[NCLK-1] - rise[NCLK], TMO + 1);
      check(fall[0] - rise[NCLK] == TMO + NCLK, "R2", "phy clock cleared last",
            fall[0] - rise[NCLK], TMO + NCLK);
      check(terr == fall[0], "R2", "error with last clear", terr, fall[0]);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    run(1, 1, 1, -1, 0);
    run(1, 0, 0, -1, 0);
    run(0, 1, 1, -1, 0);
    run(0, 0, 0, -1, 0);
    run(1, 1, 0, 0, 0);
    run(1, 0, 1, 1, 0);
    run(0, 0, 1, 2, 0);
    run(1, 1, 1, NCLK, 0);
    run(1, 0, 1, -1, 1);
    run(1, 1, 0, -1, 1);
    run(0, 1, 1, -1, 2);
    for (int k = 0; k < 8; k++) begin
      int b;
      b = ($urandom_range(0, 3) == 0) ? $urandom_range(0, NCLK) : -1;
      run(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 1)), b, 0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule